// File: doc/BRIEF.md
# Shared Scaler Ownership Arbiter

This block decides which media engine owns each of a small number of shared scaler/format-converter units. Four video-decode engines and two video-enhancement engines are hard-wired to the units. Each decode engine uses unit `i>>1`, and each enhancement engine uses unit `i`. An engine holds its lock request high until it is granted. It then keeps the unit until it pulses its release input. Engines that contend for the same free unit are served in rotating order.

Before resetting an engine, a reset controller raises that engine's forced-lock input. The unit's ownership then freezes. A locked unit keeps its current owner and ignores releases. A free unit stays free and turns away every request. The engine's acknowledge output tells the controller when the freeze has taken effect. The controller then reads the usage bit to learn whether the frozen unit belongs to the engine being reset, and whether the unit must be reset as well. The per-unit synchronous reset input clears an owner. An enable mask can shut individual decode engines out of the shared units; the mask is changed only while `rst_n` is low.

All pins are plain control and status signals sampled on the rising clock edge. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `scl_share_arb`

## Requirements
- R1: Decode engine e competes only for unit e>>1. Its status pair is `dec_status[2e+1:2e]`, with usage in bit 2e and acknowledge in bit 2e+1.
- R2: Enhancement engine e competes only for unit e. It reports acknowledge on `enh_ack[e]` and usage on `enh_usage[e]`.
- R3: A lock request sampled while the unit is free and not frozen makes the unit owned on that edge, so usage reads 1 from the next cycle. Usage reads 1 exactly when the engine's unit is locked to that engine. Requests from other engines never take an owned unit.
- R4: A release from the owner, sampled while the unit is not frozen, frees the unit on that edge. No new grant happens on that same edge. A release from an engine that is not the owner has no effect.
- R5: Each unit ranks its requesters as index 0 (lower decode engine), index 1 (upper decode engine) and index 2 (enhancement engine). A new grant goes to the first requester after the last granted index, in cyclic order. After reset, index 0 ranks first.
- R6: A decode engine whose `dec_access_en` bit is 0 is never granted. Its release does nothing, and its forced lock neither raises its acknowledge nor freezes the unit.
- R7: While any enabled engine of a unit holds forced-lock, a locked unit keeps its owner and ignores releases.
- R8: While any enabled engine of a unit holds forced-lock, a free unit stays free. Arbitration resumes on the edge where the last forced-lock is sampled low.
- R9: An engine's acknowledge is 1 in the cycle after its effective forced-lock is sampled high. It is 0 in the cycle after it is sampled low.
- R10: `unit_reset[u]` frees unit u on that edge, even while the unit is frozen. A forced lock that is still held keeps blocking new grants after the unit reset.
- R11: After `rst_n` is released, every usage and acknowledge output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_access_en | input | 4 | Per decode engine: 1 lets it use its shared unit |
| dec_lock_req | input | 4 | Decode engine lock request, held until granted |
| dec_release | input | 4 | Decode engine release pulse |
| dec_force | input | 4 | Decode engine forced-lock (freeze) request |
| enh_lock_req | input | 2 | Enhancement engine lock request |
| enh_release | input | 2 | Enhancement engine release pulse |
| enh_force | input | 2 | Enhancement engine forced-lock request |
| unit_reset | input | 2 | Per-unit synchronous owner clear |
| dec_status | output | 8 | Per decode engine: {acknowledge, usage} |
| enh_ack | output | 2 | Enhancement engine acknowledge |
| enh_usage | output | 2 | Enhancement engine usage |

## Verification
The bench targets the edges where a freeze meets other traffic:
- A release that arrives during a freeze. A design that honoured it would let ownership change after the acknowledge had promised it would not.
- A request waiting on a frozen free unit. A design that granted it would hand the unit to an engine during a reset.
- The edge where the force drops. A design that resumed late would grant one cycle after the acknowledge falls.
- A unit reset under a held freeze. A design that let the reset also end the freeze would grant immediately.

Separate checks cover:
- the rotation order after a release, where fixed priority would starve the enhancement engine;
- non-owner releases;
- masked engines whose forced lock would wrongly freeze their neighbour.

Mask-varied sweeps then compare every output each cycle against an arithmetic model.

// File: rtl/scl_share_pkg.sv
package scl_share_pkg;
  // Bit positions inside a decode engine's status pair.
  localparam int STAT_USE_BIT = 0;
  localparam int STAT_ACK_BIT = 1;
  localparam int STAT_W       = 2;

  // Shared unit a decode engine is wired to.
  function automatic int dec_unit(input int eng, input int per_unit);
    return eng / per_unit;
  endfunction

  // Requester slot of a decode engine inside its unit.
  function automatic int dec_slot(input int eng, input int per_unit);
    return eng % per_unit;
  endfunction
endpackage

// File: rtl/scl_rr_pick.sv
module scl_rr_pick #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // Scan from farthest to nearest so the nearest slot after 'last' wins.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      int c;
      c = (int'(last) + k) % N;
      if (req[c]) begin
        valid = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/scl_unit_ctl.sv
module scl_unit_ctl #(
  parameter int RQ = 3,
  localparam int IW = (RQ > 1) ? $clog2(RQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_rst,
  input  logic [RQ-1:0] req,
  input  logic [RQ-1:0] rel,
  input  logic          frz,
  output logic          locked,
  output logic [IW-1:0] owner
);
  logic [IW-1:0] last_q;
  logic          pick_v;
  logic [IW-1:0] pick_idx;

  scl_rr_pick #(.N(RQ)) u_pick (
    .req   (req),
    .last  (last_q),
    .valid (pick_v),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      last_q <= IW'(RQ - 1);
    end else if (unit_rst) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (!frz) begin
      if (locked) begin
        if (rel[owner]) locked <= 1'b0;
      end else if (pick_v) begin
        locked <= 1'b1;
        owner  <= pick_idx;
        last_q <= pick_idx;
      end
    end
  end

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !unit_rst) |=> ($stable(locked) && (!locked || $stable(owner))));

  // R3
  grant_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !frz && !unit_rst && (req != '0)) |=> locked);

  // R4
  owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !frz && !unit_rst && rel[owner]) |=> !locked);

  // R10
  unit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst |=> !locked);
endmodule

// File: rtl/scl_eng_status.sv
module scl_eng_status #(
  parameter int IW     = 2,
  parameter int MY_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frc,
  input  logic          locked,
  input  logic [IW-1:0] owner,
  output logic          ack,
  output logic          usage
);
  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= frc;
  end

  assign usage = locked && (owner == IW'(MY_IDX));

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> ack);

  // R9
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frc |=> !ack);
endmodule

// File: rtl/scl_share_arb.sv
module scl_share_arb #(
  parameter int NUM_UNIT     = 2,
  parameter int DEC_PER_UNIT = 2,
  localparam int NUM_DEC = NUM_UNIT * DEC_PER_UNIT,
  localparam int RQ      = DEC_PER_UNIT + 1,
  localparam int IW      = $clog2(RQ)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DEC-1:0]    dec_access_en,
  input  logic [NUM_DEC-1:0]    dec_lock_req,
  input  logic [NUM_DEC-1:0]    dec_release,
  input  logic [NUM_DEC-1:0]    dec_force,
  input  logic [NUM_UNIT-1:0]   enh_lock_req,
  input  logic [NUM_UNIT-1:0]   enh_release,
  input  logic [NUM_UNIT-1:0]   enh_force,
  input  logic [NUM_UNIT-1:0]   unit_reset,
  output logic [2*NUM_DEC-1:0]  dec_status,
  output logic [NUM_UNIT-1:0]   enh_ack,
  output logic [NUM_UNIT-1:0]   enh_usage
);
  import scl_share_pkg::*;

  logic [NUM_UNIT-1:0] unit_locked;
  logic [IW-1:0]       unit_owner [NUM_UNIT];
  logic [NUM_DEC-1:0]  dec_frc_eff;
  logic [NUM_DEC-1:0]  dec_ack_w;
  logic [NUM_DEC-1:0]  dec_use_w;

  assign dec_frc_eff = dec_force & dec_access_en;

  for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
    logic [RQ-1:0] u_req;
    logic [RQ-1:0] u_rel;
    logic [RQ-1:0] u_frc;

    for (genvar j = 0; j < DEC_PER_UNIT; j++) begin : g_slot
      localparam int E = u * DEC_PER_UNIT + j;
      assign u_req[j] = dec_lock_req[E] & dec_access_en[E];
      assign u_rel[j] = dec_release[E]  & dec_access_en[E];
      assign u_frc[j] = dec_frc_eff[E];
    end
    assign u_req[RQ-1] = enh_lock_req[u];
    assign u_rel[RQ-1] = enh_release[u];
    assign u_frc[RQ-1] = enh_force[u];

    scl_unit_ctl #(.RQ(RQ)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .unit_rst (unit_reset[u]),
      .req      (u_req),
      .rel      (u_rel),
      .frz      (|u_frc),
      .locked   (unit_locked[u]),
      .owner    (unit_owner[u])
    );

    scl_eng_status #(.IW(IW), .MY_IDX(RQ - 1)) u_enh_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .frc    (enh_force[u]),
      .locked (unit_locked[u]),
      .owner  (unit_owner[u]),
      .ack    (enh_ack[u]),
      .usage  (enh_usage[u])
    );
  end

  for (genvar e = 0; e < NUM_DEC; e++) begin : g_dec
    localparam int U = dec_unit(e, DEC_PER_UNIT);
    localparam int J = dec_slot(e, DEC_PER_UNIT);

    scl_eng_status #(.IW(IW), .MY_IDX(J)) u_dec_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .frc    (dec_frc_eff[e]),
      .locked (unit_locked[U]),
      .owner  (unit_owner[U]),
      .ack    (dec_ack_w[e]),
      .usage  (dec_use_w[e])
    );

    assign dec_status[STAT_W*e + STAT_USE_BIT] = dec_use_w[e];
    assign dec_status[STAT_W*e + STAT_ACK_BIT] = dec_ack_w[e];

    // R6
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_access_en[e] |-> (!dec_status[STAT_W*e + STAT_USE_BIT] &&
                             !dec_status[STAT_W*e + STAT_ACK_BIT]));
  end
endmodule

// File: tb/scl_share_arb_bench.sv
`timescale 1ns/1ps
module scl_share_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dec_access_en = 4'hF;
  logic [3:0] dec_lock_req = '0, dec_release = '0, dec_force = '0;
  logic [1:0] enh_lock_req = '0, enh_release = '0, enh_force = '0;
  logic [1:0] unit_reset = '0;
  logic [7:0] dec_status;
  logic [1:0] enh_ack, enh_usage;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_share_arb u_scl_share_arb (
    .clk(clk), .rst_n(rst_n), .dec_access_en(dec_access_en),
    .dec_lock_req(dec_lock_req), .dec_release(dec_release), .dec_force(dec_force),
    .enh_lock_req(enh_lock_req), .enh_release(enh_release), .enh_force(enh_force),
    .unit_reset(unit_reset), .dec_status(dec_status), .enh_ack(enh_ack),
    .enh_usage(enh_usage)
  );

  // Reference model from the requirements: slot 0/1 decode, slot 2 enhancement.
  int m_lk [2];
  int m_ow [2];
  int m_pt [2];
  bit m_dack [4];
  bit m_eack [2];

  always @(posedge clk) begin
    bit rq [3];
    bit rl [3];
    bit fz;
    bit found;
    int c;
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin m_lk[u] = 0; m_ow[u] = 0; m_pt[u] = 2; m_eack[u] = 0; end
      for (int e = 0; e < 4; e++) m_dack[e] = 0;
    end else begin
      for (int u = 0; u < 2; u++) begin
        fz = 0;
        for (int j = 0; j < 2; j++) begin
          rq[j] = dec_lock_req[2*u+j] && dec_access_en[2*u+j];
          rl[j] = dec_release[2*u+j]  && dec_access_en[2*u+j];
          fz = fz || (dec_force[2*u+j] && dec_access_en[2*u+j]);
        end
        rq[2] = enh_lock_req[u];
        rl[2] = enh_release[u];
        fz = fz || enh_force[u];
        if (unit_reset[u]) begin
          m_lk[u] = 0; m_ow[u] = 0;
        end else if (!fz) begin
          if (m_lk[u] != 0) begin
            if (rl[m_ow[u]]) m_lk[u] = 0;
          end else begin
            found = 0;
            for (int k = 1; k <= 3; k++) begin
              c = (m_pt[u] + k) % 3;
              if (!found && rq[c]) begin
                found = 1; m_lk[u] = 1; m_ow[u] = c; m_pt[u] = c;
              end
            end
          end
        end
        m_eack[u] = enh_force[u];
      end
      for (int e = 0; e < 4; e++) m_dack[e] = dec_force[e] && dec_access_en[e];
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic cmp_model();
    logic [7:0] ed;
    logic [1:0] ea, eu;
    for (int e = 0; e < 4; e++) begin
      ed[2*e]   = (m_lk[e/2] != 0) && (m_ow[e/2] == e%2);
      ed[2*e+1] = m_dack[e];
    end
    for (int u = 0; u < 2; u++) begin
      ea[u] = m_eack[u];
      eu[u] = (m_lk[u] != 0) && (m_ow[u] == 2);
    end
    n_cmp++;
    if (dec_status !== ed || enh_ack !== ea || enh_usage !== eu) begin
      n_bad++;
      $display("FAIL R3 sweep: got %h/%b/%b expected %h/%b/%b",
               dec_status, enh_ack, enh_usage, ed, ea, eu);
    end
  endtask

  task automatic clear_in();
    dec_lock_req = '0; dec_release = '0; dec_force = '0;
    enh_lock_req = '0; enh_release = '0; enh_force = '0; unit_reset = '0;
  endtask

  task automatic do_reset(input logic [3:0] mask);
    clear_in();
    rst_n = 1'b0;
    dec_access_en = mask;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(4'hF);
    step();
    chk("R11", "dec_status", |dec_status, 1'b0);
    chk("R11", "enh outputs", |{enh_ack, enh_usage}, 1'b0);

    // R1 / R3: grant and hold
    dec_lock_req[1] = 1; step();
    chk("R1", "dec1 usage bit2", dec_status[2], 1'b1);
    chk("R1", "unit1 untouched", dec_status[6], 1'b0);
    dec_lock_req[0] = 1; step();
    chk("R3", "dec0 no steal", dec_status[0], 1'b0);
    chk("R3", "dec1 kept", dec_status[2], 1'b1);

    // R1 / R2 / R4 on unit 1
    dec_lock_req[3] = 1; step();
    chk("R1", "dec3 usage bit6", dec_status[6], 1'b1);
    enh_lock_req[1] = 1; step();
    chk("R2", "enh1 waits", enh_usage[1], 1'b0);
    dec_lock_req[3] = 0; dec_release[3] = 1; step(); dec_release[3] = 0;
    chk("R4", "dec3 freed", dec_status[6], 1'b0);
    chk("R4", "no same-edge grant", enh_usage[1], 1'b0);
    step();
    chk("R2", "enh1 granted", enh_usage[1], 1'b1);
    enh_lock_req[1] = 0;

    // R4: non-owner release
    dec_release[0] = 1; step(); dec_release[0] = 0;
    chk("R4", "non-owner release ignored", dec_status[2], 1'b1);

    // R5: rotation after dec1 (slot 1): enh0 before dec0
    enh_lock_req[0] = 1; dec_lock_req[1] = 0; dec_release[1] = 1; step(); dec_release[1] = 0;
    step();
    chk("R5", "enh0 next after slot1", enh_usage[0], 1'b1);
    chk("R5", "dec0 passed over", dec_status[0], 1'b0);
    enh_lock_req[0] = 0; enh_release[0] = 1; dec_lock_req[1] = 1; step(); enh_release[0] = 0;
    step();
    chk("R5", "dec0 next after slot2", dec_status[0], 1'b1);
    chk("R5", "dec1 passed over", dec_status[2], 1'b0);

    // R7 / R9: freeze a locked unit
    dec_force[1] = 1; step();
    chk("R9", "dec1 ack rises", dec_status[3], 1'b1);
    dec_lock_req[0] = 0; dec_release[0] = 1; step(); dec_release[0] = 0;
    chk("R7", "owner kept under freeze", dec_status[0], 1'b1);
    chk("R7", "waiter not granted", dec_status[2], 1'b0);
    dec_force[1] = 0; step();
    chk("R9", "dec1 ack falls", dec_status[3], 1'b0);
    dec_release[0] = 1; step(); dec_release[0] = 0;
    chk("R4", "release after freeze", dec_status[0], 1'b0);
    step();
    chk("R3", "dec1 granted", dec_status[2], 1'b1);
    dec_lock_req[1] = 0; dec_release[1] = 1; enh_release[1] = 1; step();
    dec_release[1] = 0; enh_release[1] = 0;

    // R8: freeze a free unit
    enh_force[0] = 1; dec_lock_req[0] = 1; step();
    chk("R9", "enh0 ack rises", enh_ack[0], 1'b1);
    chk("R8", "frozen free unit rejects", dec_status[0], 1'b0);
    step();
    chk("R8", "still rejected", dec_status[0], 1'b0);
    enh_force[0] = 0; step();
    chk("R9", "enh0 ack falls", enh_ack[0], 1'b0);
    chk("R8", "grant on drop edge", dec_status[0], 1'b1);
    dec_lock_req[0] = 0;

    // R10: unit reset under held freeze
    dec_lock_req[2] = 1; step();
    chk("R10", "dec2 owns unit1", dec_status[4], 1'b1);
    enh_force[1] = 1; unit_reset[1] = 1; dec_lock_req[3] = 1; step(); unit_reset[1] = 0;
    chk("R10", "owner cleared", dec_status[4], 1'b0);
    step();
    chk("R10", "freeze still blocks", dec_status[6] | dec_status[4], 1'b0);
    enh_force[1] = 0; step();
    chk("R10", "resume to dec3", dec_status[6], 1'b1);

    // R6: masked decode engine 2
    do_reset(4'b1011);
    dec_lock_req[2] = 1; step(); step();
    chk("R6", "masked never granted", dec_status[4], 1'b0);
    dec_force[2] = 1; dec_lock_req[3] = 1; step();
    chk("R6", "masked ack stays 0", dec_status[5], 1'b0);
    chk("R6", "masked force no freeze", dec_status[6], 1'b1);

    // Sweeps against the model
    for (int s = 0; s < 4; s++) begin
      logic [3:0] mk;
      mk = (s == 0) ? 4'hF : (s == 1) ? 4'hE : (s == 2) ? 4'hB : 4'h5;
      do_reset(mk);
      for (int n = 0; n < 500; n++) begin
        dec_lock_req = 4'($urandom);
        dec_release  = 4'($urandom) & 4'($urandom);
        dec_force    = 4'($urandom) & 4'($urandom) & 4'($urandom);
        enh_lock_req = 2'($urandom);
        enh_release  = 2'($urandom) & 2'($urandom);
        enh_force    = 2'($urandom) & 2'($urandom) & 2'($urandom);
        unit_reset   = 2'($urandom) & 2'($urandom) & 2'($urandom) & 2'($urandom);
        step();
        cmp_model();
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule